// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block sits between an A bus and a B bus and moves data in either direction. Each direction owns a storage register with its own capture clock. A select input for each direction decides whether the side being driven carries the live value from the opposite bus or the value held in that direction's register. An enable for each direction decides whether that side is driven at all. Each pad is modelled as three separate signals: the value coming in, the value going out, and an output enable.

The data path is split into independent lanes, by default two lanes of 8 bits. Each lane has its own full set of clocks, selects and enables. Driving every lane's controls from the same sources makes the block act as one 16-bit transceiver. The selects and enables support four ways of using the bus. Live transfer passes data straight through. Stored transfer drives the registered value. Store-only captures data while both sides stay undriven. In the fourth way both directions are enabled in live mode, so each side drives back the value it sees on the other side.

The select multiplexer uses a consensus term. As a result, a bit whose live and stored values agree holds steady while the select changes.

Top module: `regbus_xcvr`

## Requirements
- R1: On a rising edge of lane k's bit of `clk_ab`, the A-to-B register of lane k loads `a_in[k*8 +: 8]`. On a rising edge of lane k's bit of `clk_ba`, the B-to-A register of lane k loads `b_in[k*8 +: 8]`.
- R2: Register capture happens on every such clock edge, whatever the values of the select and enable inputs.
- R3: When `sel_ab[k]` is 0, `b_out` of lane k equals the live `a_in` of lane k. When `sel_ab[k]` is 1, it equals the A-to-B register of lane k. The same rule holds for `sel_ba[k]` and `a_out`, using `b_in` and the B-to-A register. The output follows without a clock.
- R4: Every bit of `b_oe` in lane k is 1 exactly when `oe_ab[k]` is 1, since that enable is active-high. Every bit of `a_oe` in lane k is 1 exactly when `oe_ba_n[k]` is 0, since that enable is active-low.
- R5: Each output bit always equals either its live input bit or its stored bit, never any other value. A bit whose live and stored values agree does not change when its select toggles.
- R6: The controls of lane k affect only the bits of lane k.
- R7: When `rst_n` is low, all storage registers in all lanes clear to zero at once, without waiting for a clock.
- R8: With both selects at 0 and both directions enabled, `b_out` equals `a_in`, `a_out` equals `b_in`, and every bit of both enables is 1.
- R9: With both directions disabled, clock edges still load the registers. A later change of the selects to 1 shows the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of all registers |
| clk_ab | input | 2 | Per-lane capture clock of the A-to-B register |
| clk_ba | input | 2 | Per-lane capture clock of the B-to-A register |
| sel_ab | input | 2 | Per-lane B-side source: 0 live A, 1 stored |
| sel_ba | input | 2 | Per-lane A-side source: 0 live B, 1 stored |
| oe_ab | input | 2 | Per-lane B-side drive enable, active-high |
| oe_ba_n | input | 2 | Per-lane A-side drive enable, active-low |
| a_in | input | 16 | Value present on the A bus |
| a_out | output | 16 | Value to drive onto the A bus |
| a_oe | output | 16 | Per-bit A pad output enable |
| b_in | input | 16 | Value present on the B bus |
| b_out | output | 16 | Value to drive onto the B bus |
| b_oe | output | 16 | Per-bit B pad output enable |

## Verification
Random values on both buses are mixed with random per-lane selects, enables and clock pulses. This separates live from stored sourcing, and it shows whether a clock pulse reaches only its own lane and direction. Directed patterns cover the four bus-usage modes; the store-only case shows that capture ignores the enables. A select toggle with equal live and stored values checks that the output holds steady. A reset in mid-run with stored data selected shows the asynchronous clear. Every random step also checks each output bit against its live and stored bits, to catch any value that mixes the two.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.data;

    // R1 / R2: every edge loads the input, no other control involved
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(din)));
endmodule

// File: rtl/xcvr_sel.sv
module xcvr_sel #(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);
    import xcvr_pkg::*;

    src_e         src;
    logic [W-1:0] pick_live, pick_stored, agree;

    always_comb begin
        src         = src_e'(sel);
        pick_live   = live   & {W{src == SRC_LIVE}};
        pick_stored = stored & {W{src == SRC_STORED}};
        agree       = live & stored;
        y           = pick_live | pick_stored | agree;
    end

    always_comb begin
        a_r5_no_mix: assert (((y ^ live) & (y ^ stored)) == '0);
        if (sel == 1'b0) begin
            a_r3_live_src: assert (y == live);
        end else begin
            a_r3_stored_src: assert (y == stored);
        end
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    logic [W-1:0] held_ab, held_ba;

    xcvr_store #(.W(W)) u_st_ab (.rst_n(rst_n), .clk(clk_ab), .din(a_in), .q(held_ab));
    xcvr_store #(.W(W)) u_st_ba (.rst_n(rst_n), .clk(clk_ba), .din(b_in), .q(held_ba));

    xcvr_sel #(.W(W)) u_mx_ab (.sel(sel_ab), .live(a_in), .stored(held_ab), .y(b_out));
    xcvr_sel #(.W(W)) u_mx_ba (.sel(sel_ba), .live(b_in), .stored(held_ba), .y(a_out));

    always_comb begin
        b_oe = {W{oe_ab}};
        a_oe = {W{~oe_ba_n}};
    end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int BUS_W = LANE_W * LANES
) (
    input  logic             rst_n,
    input  logic [LANES-1:0] clk_ab,
    input  logic [LANES-1:0] clk_ba,
    input  logic [LANES-1:0] sel_ab,
    input  logic [LANES-1:0] sel_ba,
    input  logic [LANES-1:0] oe_ab,
    input  logic [LANES-1:0] oe_ba_n,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] a_out,
    output logic [BUS_W-1:0] a_oe,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic [BUS_W-1:0] b_oe
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        xcvr_lane #(.W(LANE_W)) u_lane (
            .rst_n  (rst_n),
            .clk_ab (clk_ab[k]),
            .clk_ba (clk_ba[k]),
            .sel_ab (sel_ab[k]),
            .sel_ba (sel_ba[k]),
            .oe_ab  (oe_ab[k]),
            .oe_ba_n(oe_ba_n[k]),
            .a_in   (a_in[k*LANE_W +: LANE_W]),
            .a_out  (a_out[k*LANE_W +: LANE_W]),
            .a_oe   (a_oe[k*LANE_W +: LANE_W]),
            .b_in   (b_in[k*LANE_W +: LANE_W]),
            .b_out  (b_out[k*LANE_W +: LANE_W]),
            .b_oe   (b_oe[k*LANE_W +: LANE_W])
        );
    end
endmodule

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;
    localparam int LW = 8;
    localparam int NL = 2;
    localparam int BW = LW * NL;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic [NL-1:0] clk_ab, clk_ba, sel_ab, sel_ba, oe_ab, oe_ba_n;
    logic [BW-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;

    regbus_xcvr #(.LANE_W(LW), .LANES(NL)) u0 (
        .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .sel_ab(sel_ab),
        .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .a_in(a_in),
        .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [BW-1:0] m_ab, m_ba;

    task automatic check(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] pick(logic [NL-1:0] s, logic [BW-1:0] live,
                                           logic [BW-1:0] held);
        logic [BW-1:0] r;
        for (int k = 0; k < NL; k++)
            r[k*LW +: LW] = s[k] ? held[k*LW +: LW] : live[k*LW +: LW];
        return r;
    endfunction

    function automatic logic [BW-1:0] spread(logic [NL-1:0] e);
        logic [BW-1:0] r;
        for (int k = 0; k < NL; k++) r[k*LW +: LW] = {LW{e[k]}};
        return r;
    endfunction

    task automatic pulse(logic [NL-1:0] pab, logic [NL-1:0] pba);
        #1;
        clk_ab = pab;
        clk_ba = pba;
        for (int k = 0; k < NL; k++) begin
            if (pab[k]) m_ab[k*LW +: LW] = a_in[k*LW +: LW];
            if (pba[k]) m_ba[k*LW +: LW] = b_in[k*LW +: LW];
        end
        #0.5;
        clk_ab = '0;
        clk_ba = '0;
        #0.5;
    endtask

    task automatic check_all(string tag);
        check({tag, " R3 b_out"}, b_out, pick(sel_ab, a_in, m_ab));
        check({tag, " R3 a_out"}, a_out, pick(sel_ba, b_in, m_ba));
        check({tag, " R4 b_oe"}, b_oe, spread(oe_ab));
        check({tag, " R4 a_oe"}, a_oe, spread(~oe_ba_n));
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b1; clk_ab = '0; clk_ba = '0;
        sel_ab = '1; sel_ba = '1; oe_ab = '0; oe_ba_n = '1;
        a_in = 16'hA5A5; b_in = 16'h5A5A;
        m_ab = '0; m_ba = '0;
        #2 rst_n = 1'b0;
        #3;
        check("R7 reset b_out", b_out, '0);
        check("R7 reset a_out", a_out, '0);
        check("R4 reset b_oe off", b_oe, '0);
        check("R4 reset a_oe off", a_oe, '0);
        @(negedge clk); rst_n = 1'b1;

        // R9 store-only: both disabled, capture, then show stored
        @(negedge clk);
        a_in = 16'h1234; b_in = 16'hBEEF;
        pulse('1, '1);
        check("R9 store-only b_oe", b_oe, '0);
        check("R9 store-only a_oe", a_oe, '0);
        a_in = 16'h0000; b_in = 16'hFFFF; #1;
        check("R9 stored b_out", b_out, 16'h1234);
        check("R9 stored a_out", a_out, 16'hBEEF);

        // R8 both directions live and enabled
        @(negedge clk);
        sel_ab = '0; sel_ba = '0; oe_ab = '1; oe_ba_n = '0;
        a_in = 16'hC3E1; b_in = 16'h7E18; #1;
        check("R8 b_out=a_in", b_out, 16'hC3E1);
        check("R8 a_out=b_in", a_out, 16'h7E18);
        check("R8 b_oe on", b_oe, '1);
        check("R8 a_oe on", a_oe, '1);

        // R2 capture while live and enabled, then stored transfer
        a_in = 16'h0F0F; b_in = 16'hF00F;
        pulse('1, '1);
        sel_ab = '1; sel_ba = '1; a_in = 16'h9999; b_in = 16'h6666; #1;
        check("R2 capture during live b_out", b_out, 16'h0F0F);
        check("R2 capture during live a_out", a_out, 16'hF00F);

        // R6 lane isolation: pulse only lane 0 A-to-B, lane 1 B-to-A
        @(negedge clk);
        a_in = 16'h4411; b_in = 16'h2288;
        pulse(2'b01, 2'b10);
        check("R6 lane isolation b_out", b_out, 16'h0F11);
        check("R6 lane isolation a_out", a_out, 16'h220F);
        sel_ab = 2'b10; #1;
        check("R6 per-lane select b_out", b_out, 16'h0F11);
        a_in = 16'hAB00; #1;
        check("R6 per-lane select live lane0", b_out, 16'h0F00);

        // R5 equal live and stored: toggling select leaves output steady
        @(negedge clk);
        a_in = 16'h5C3A; pulse('1, '0);
        sel_ab = '0; #0.5;
        check("R5 steady sel=0", b_out, 16'h5C3A);
        sel_ab = '1; #0.5;
        check("R5 steady sel=1", b_out, 16'h5C3A);
        sel_ab = '0; #0.5;
        check("R5 steady sel back", b_out, 16'h5C3A);

        // random mix
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            a_in = BW'($urandom); b_in = BW'($urandom);
            sel_ab = NL'($urandom); sel_ba = NL'($urandom);
            oe_ab = NL'($urandom); oe_ba_n = NL'($urandom);
            #0.5;
            check_all("rand pre");
            pulse(NL'($urandom), NL'($urandom));
            check_all("R1 rand post");
            n_chk++;
            if ((((b_out ^ a_in) & (b_out ^ m_ab)) | ((a_out ^ b_in) & (a_out ^ m_ba))) != '0) begin
                n_bad++;
                $display("FAIL R5 mixed value actual=%h/%h expected live %h/%h or stored %h/%h",
                         b_out, a_out, a_in, b_in, m_ab, m_ba);
            end
        end

        // R7 mid-run reset with stored selected
        @(negedge clk);
        sel_ab = '1; sel_ba = '1;
        rst_n = 1'b0; m_ab = '0; m_ba = '0; #1;
        check("R7 mid reset b_out", b_out, '0);
        check("R7 mid reset a_out", a_out, '0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule